// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Single-Pin Edge Interrupt

The block is a 16-pin general-purpose I/O port behind a small word-addressed register bus. Software sets an output value and a direction for each pin. It reads back pin levels through a two-stage synchronizer. Each pin either belongs to the port or passes through an alternate function supplied from outside.

One pin at a time can be watched for a chosen edge. When the selected edge occurs, a sticky GPIO flag is set in a status register. A keypad request from outside appears as a second flag in the same register, and each flag has its own mask bit. Reading the status register clears only the GPIO flag. A control bit freezes the synchronizer and the edge logic, while register access continues to work.

Register word addresses:

| Address | Register |
|---|---|
| 0 | output data |
| 1 | direction |
| 2 | input levels (read only) |
| 3 | control |
| 4 | function select |
| 5 | event select |
| 6 | status (read only) |
| 7 | mask |

Top module: `gpio_evt_port`

## Requirements
- R1: The output register (address 0) drives `pad_out` on pins whose function-select bit is 1. On such a pin, `pad_oe` is the inverse of the direction bit (address 1): direction bit 1 means input, 0 means output.
- R2: After reset, the registers hold these values: direction 0xFFFF, function select 0, output 0, control 0, event select 0, mask 0x0003, and the GPIO flag is 0.
- R3: Reading address 2 returns bit n equal to the level of `pad_in[n]`. A change on the pin becomes visible after two enabled clock edges.
- R4: On a pin whose function-select bit (address 4) is 0, `pad_out` and `pad_oe` follow `alt_out` and `alt_oe` for that pin.
- R5: Control bit 5 is the clock enable. While it is 0, the synchronizer and the edge logic hold their state, and a pin change neither shows at address 2 nor sets the flag. Register reads and writes still take effect.
- R6: The event-select register (address 5) has this layout: bit 0 enables watching, bits 4:1 give the pin number, and bit 5 gives the edge (1 rising, 0 falling). A matching edge sets the GPIO flag (status bit 1) at the third enabled clock edge after the pin changes.
- R7: The GPIO flag is not set by any of the following: an edge on another pin, the opposite edge, or an edge while bit 0 of the event-select register is 0.
- R8: A read of the status register (address 6) clears the GPIO flag. Status bit 0 follows the level of `kbd_req` and is not changed by the read.
- R9: If a status read and a matching edge fall in the same cycle, the GPIO flag stays set.
- R10: Mask bit 0 masks the keypad flag and mask bit 1 masks the GPIO flag, where 1 means masked. `irq` is high when either flag is set with its mask bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a status read clears the GPIO flag) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid during `bus_rd`, 0 otherwise |
| pad_in | input | 16 | Pin levels from the pads |
| pad_out | output | 16 | Value driven to the pads |
| pad_oe | output | 16 | Output enable per pad |
| alt_out | input | 16 | Alternate-function output value |
| alt_oe | input | 16 | Alternate-function output enable |
| kbd_req | input | 1 | Keypad interrupt request level |
| irq | output | 1 | Combined interrupt |

## Verification
The status read that clears the GPIO flag can land in the same cycle as a newly detected matching edge that sets it. The bench provokes this by changing the watched pin and then timing the status read to the cycle after the second enabled clock edge. It then checks that a second read finds the flag still set. The same clear-on-read is also checked against the keypad bit, which must keep showing the live `kbd_req` level across the read.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    localparam int NPINS     = 16;
    localparam int PIN_W     = $clog2(NPINS);
    localparam int ADDR_W    = 3;
    localparam int CLKEN_BIT = 5;
    localparam int EVT_W     = PIN_W + 2;
    localparam logic [NPINS-1:0] DIR_RESET = '1;

    typedef enum logic [ADDR_W-1:0] {
        A_OUT  = 3'd0,
        A_DIR  = 3'd1,
        A_IN   = 3'd2,
        A_CTRL = 3'd3,
        A_FUNC = 3'd4,
        A_EVT  = 3'd5,
        A_STAT = 3'd6,
        A_MASK = 3'd7
    } reg_addr_e;

    // bit 5 edge, bits 4:1 pin, bit 0 enable
    typedef struct packed {
        logic             rise;
        logic [PIN_W-1:0] pin;
        logic             en;
    } evt_cfg_t;

    // bit 1 gpio, bit 0 keypad
    typedef struct packed {
        logic gpio;
        logic kbd;
    } irq_vec_t;

    function automatic logic edge_match(evt_cfg_t c, logic now_v, logic old_v);
        if (!c.en) return 1'b0;
        return c.rise ? (now_v & ~old_v) : (~now_v & old_v);
    endfunction

endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync
    import gpio_evt_pkg::*;
#(
    parameter int W = NPINS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clken,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] sync_q,
    output logic [W-1:0] prev_q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else if (clken) begin
            stage1 <= pad_in;
            sync_q <= stage1;
            prev_q <= sync_q;
        end
    end

    assert_hold_when_gated_R5: assert property (@(posedge clk) disable iff (rst)
        !clken |=> $stable(sync_q) && $stable(prev_q));

endmodule

// File: rtl/gpio_evt_pads.sv
module gpio_evt_pads
    import gpio_evt_pkg::*;
#(
    parameter int W = NPINS
) (
    input  logic [W-1:0] func_sel,
    input  logic [W-1:0] out_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] alt_out,
    input  logic [W-1:0] alt_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        always_comb begin
            if (func_sel[i]) begin
                pad_out[i] = out_q[i];
                pad_oe[i]  = ~dir_q[i];
            end else begin
                pad_out[i] = alt_out[i];
                pad_oe[i]  = alt_oe[i];
            end
        end
    end
endmodule

// File: rtl/gpio_evt_event.sv
module gpio_evt_event
    import gpio_evt_pkg::*;
#(
    parameter int W = NPINS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clken,
    input  evt_cfg_t     cfg,
    input  logic [W-1:0] sync_q,
    input  logic [W-1:0] prev_q,
    input  logic         stat_rd,
    input  logic         kbd_req,
    input  irq_vec_t     mask,
    output irq_vec_t     stat,
    output logic         irq
);
    logic hit;
    logic gflag;

    always_comb begin
        hit = clken & edge_match(cfg, sync_q[cfg.pin], prev_q[cfg.pin]);
    end

    always_ff @(posedge clk) begin
        if (rst)          gflag <= 1'b0;
        else if (hit)     gflag <= 1'b1;
        else if (stat_rd) gflag <= 1'b0;
    end

    always_comb begin
        stat.gpio = gflag;
        stat.kbd  = kbd_req;
        irq       = (stat.gpio & ~mask.gpio) | (stat.kbd & ~mask.kbd);
    end

    assert_edge_sets_flag_R6: assert property (@(posedge clk) disable iff (rst)
        hit |=> gflag);
    assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !hit) |=> !gflag);
    assert_read_edge_keeps_R9: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && hit) |=> gflag);
    assert_fully_masked_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (mask == 2'b11) |-> !irq);

endmodule

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs
    import gpio_evt_pkg::*;
#(
    parameter int W = NPINS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    input  logic [W-1:0]      in_sync,
    input  irq_vec_t          stat,
    output logic [W-1:0]      bus_rdata,
    output logic [W-1:0]      out_q,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      func_q,
    output logic              clken,
    output evt_cfg_t          evt_q,
    output irq_vec_t          mask_q,
    output logic              stat_rd
);
    logic [W-1:0] ctrl_q;
    reg_addr_e    addr;

    always_comb begin
        addr    = reg_addr_e'(bus_addr);
        clken   = ctrl_q[CLKEN_BIT];
        stat_rd = bus_rd && (addr == A_STAT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= '0;
            dir_q  <= DIR_RESET;
            func_q <= '0;
            ctrl_q <= '0;
            evt_q  <= '0;
            mask_q <= '1;
        end else if (bus_wr) begin
            unique case (addr)
                A_OUT:   out_q  <= bus_wdata;
                A_DIR:   dir_q  <= bus_wdata;
                A_CTRL:  ctrl_q <= bus_wdata;
                A_FUNC:  func_q <= bus_wdata;
                A_EVT:   evt_q  <= evt_cfg_t'(bus_wdata[EVT_W-1:0]);
                A_MASK:  mask_q <= irq_vec_t'(bus_wdata[1:0]);
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (addr)
                A_OUT:  bus_rdata = out_q;
                A_DIR:  bus_rdata = dir_q;
                A_IN:   bus_rdata = in_sync;
                A_CTRL: bus_rdata = ctrl_q;
                A_FUNC: bus_rdata = func_q;
                A_EVT:  bus_rdata = W'(evt_q);
                A_STAT: bus_rdata = W'(stat);
                A_MASK: bus_rdata = W'(mask_q);
                default: bus_rdata = '0;
            endcase
        end
    end

    assert_dir_after_reset_R2: assert property (@(posedge clk)
        $past(rst) |-> (dir_q == DIR_RESET && func_q == '0));

endmodule

// File: rtl/gpio_evt_port.sv
module gpio_evt_port
    import gpio_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    input  logic [NPINS-1:0]  alt_out,
    input  logic [NPINS-1:0]  alt_oe,
    input  logic              kbd_req,
    output logic              irq
);
    logic [NPINS-1:0] out_q, dir_q, func_q, sync_q, prev_q;
    logic             clken, stat_rd;
    evt_cfg_t         evt_q;
    irq_vec_t         mask_q, stat;

    gpio_evt_regs #(.W(NPINS)) u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .in_sync(sync_q),
        .stat(stat), .bus_rdata(bus_rdata), .out_q(out_q), .dir_q(dir_q),
        .func_q(func_q), .clken(clken), .evt_q(evt_q), .mask_q(mask_q),
        .stat_rd(stat_rd)
    );

    gpio_evt_sync #(.W(NPINS)) u_sync (
        .clk(clk), .rst(rst), .clken(clken), .pad_in(pad_in),
        .sync_q(sync_q), .prev_q(prev_q)
    );

    gpio_evt_event #(.W(NPINS)) u_event (
        .clk(clk), .rst(rst), .clken(clken), .cfg(evt_q), .sync_q(sync_q),
        .prev_q(prev_q), .stat_rd(stat_rd), .kbd_req(kbd_req),
        .mask(mask_q), .stat(stat), .irq(irq)
    );

    gpio_evt_pads #(.W(NPINS)) u_pads (
        .func_sel(func_q), .out_q(out_q), .dir_q(dir_q), .alt_out(alt_out),
        .alt_oe(alt_oe), .pad_out(pad_out), .pad_oe(pad_oe)
    );

endmodule

// File: tb/tb_gpio_evt_port.sv
module tb_gpio_evt_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic [15:0] pad_in = '0, pad_out, pad_oe, alt_out = '0, alt_oe = '0;
    logic        kbd_req = 1'b0, irq;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [15:0] m_out = '0, m_dir = 16'hFFFF, m_func = '0;

    gpio_evt_port dut (.*);

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] exp_out(input logic [15:0] ao);
        return (m_func & m_out) | (~m_func & ao);
    endfunction
    function automatic logic [15:0] exp_oe(input logic [15:0] ae);
        return (m_func & ~m_dir) | (~m_func & ae);
    endfunction
    function automatic bit exp_hit(input bit en, input bit rise, input bit o, input bit n);
        return en && (rise ? (!o && n) : (o && !n));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2 reset values
        rd(1, d); check(d == 16'hFFFF, "R2 dir", d, 16'hFFFF);
        rd(4, d); check(d == 16'h0, "R2 func", d, 16'h0);
        rd(0, d); check(d == 16'h0, "R2 out", d, 16'h0);
        rd(3, d); check(d == 16'h0, "R2 ctrl", d, 16'h0);
        rd(5, d); check(d == 16'h0, "R2 evt", d, 16'h0);
        rd(7, d); check(d == 16'h3, "R2 mask", d, 16'h3);
        rd(6, d); check(d == 16'h0, "R2 stat", d, 16'h0);
        check(irq == 1'b0, "R2 irq", {15'b0, irq}, 16'h0);

        // R5: gated clock freezes input path, registers still writable
        pad_in = 16'hA5A5;
        wr(5, 16'h0021); // enable, pin0, rising
        idle(5);
        rd(2, d); check(d == 16'h0, "R5 input held", d, 16'h0);
        rd(6, d); check(d[1] == 1'b0, "R5 no event while gated", d, 16'h0);
        rd(5, d); check(d == 16'h0021, "R5 write while gated", d, 16'h0021);
        wr(3, 16'h0020);
        idle(3);
        rd(2, d); check(d == 16'hA5A5, "R3 input after enable", d, 16'hA5A5);
        rd(6, d); // clear edge seen at enable (pin0 rose)
        rd(6, d); check(d[1] == 1'b0, "R8 flag cleared", d, 16'h0);

        // R3: two-edge latency
        pad_in = 16'h1234;
        @(posedge clk); @(negedge clk);
        rd(2, d); // sampled after one edge: old value
        check(d == 16'hA5A5, "R3 one edge old", d, 16'hA5A5);
        rd(2, d); check(d == 16'h1234, "R3 settled", d, 16'h1234);

        // R1/R4 random pad mux
        for (int k = 0; k < 30; k++) begin
            m_out = 16'($urandom); m_dir = 16'($urandom); m_func = 16'($urandom);
            wr(0, m_out); wr(1, m_dir); wr(4, m_func);
            alt_out = 16'($urandom); alt_oe = 16'($urandom);
            #1;
            check(pad_out == exp_out(alt_out), "R1 R4 pad_out", pad_out, exp_out(alt_out));
            check(pad_oe == exp_oe(alt_oe), "R1 R4 pad_oe", pad_oe, exp_oe(alt_oe));
        end

        // R6/R7/R8/R10 random events
        rd(6, d);
        for (int k = 0; k < 60; k++) begin
            bit en, rise, hit;
            logic [3:0] p;
            logic [15:0] nv, ov;
            logic [1:0] mk;
            bit kb;
            en = ($urandom % 4) != 0; rise = $urandom % 2; p = 4'($urandom);
            mk = 2'($urandom); kb = $urandom % 2;
            wr(5, {10'b0, rise, p, en});
            wr(7, {14'b0, mk});
            ov = pad_in;
            nv = 16'($urandom);
            if (($urandom % 2) == 1) nv[p] = ~ov[p];
            hit = exp_hit(en, rise, ov[p], nv[p]);
            pad_in = nv;
            kbd_req = kb;
            idle(4);
            #1;
            check(irq == ((kb & !mk[0]) | (hit & !mk[1])), "R10 irq", {15'b0, irq},
                  {15'b0, (kb & !mk[0]) | (hit & !mk[1])});
            rd(6, d);
            check(d[1] == hit, hit ? "R6 flag set" : "R7 no flag", d, {14'b0, hit, kb});
            check(d[0] == kb, "R8 keypad level", d, {14'b0, hit, kb});
            rd(6, d);
            check(d == {14'b0, 1'b0, kb}, "R8 gpio cleared keypad kept", d, {14'b0, 1'b0, kb});
        end

        // R6 exact latency: falling on pin 7
        wr(7, 16'h0); kbd_req = 1'b0;
        pad_in = 16'h0080; idle(4); rd(6, d);
        wr(5, {10'b0, 1'b0, 4'd7, 1'b1});
        pad_in = 16'h0000;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd(6, d); check(d[1] == 1'b0, "R6 not before third edge", d, 16'h0);
        rd(6, d); check(d[1] == 1'b1, "R9 read meets edge keeps flag", d, 16'h2);
        rd(6, d); check(d[1] == 1'b0, "R8 later read clears", d, 16'h0);

        // R9 with rising pin 15 and R10 unmasked gpio irq
        wr(5, {10'b0, 1'b1, 4'd15, 1'b1});
        pad_in = 16'h8000;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd(6, d);
        #1 check(irq == 1'b1, "R10 gpio irq", {15'b0, irq}, 16'h1);
        rd(6, d); check(d[1] == 1'b1, "R9 flag survives read", d, 16'h2);
        #1 check(irq == 1'b0, "R10 irq drops after clear", {15'b0, irq}, 16'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule